// File: doc/BRIEF.md
# HDLC Bit-Serial Frame Transmitter

This block turns a byte stream into a one-bit HDLC line. Bytes arrive through a valid/ready handshake, and an end-of-packet flag marks the final byte of each packet. The block puts a 7Eh flag before and after each packet and computes a frame check sequence over the payload. It inserts a zero after every run of five ones in the payload and the check sequence. It can pass the line through a self-synchronous x^43+1 scrambler. When no packet is being sent, it drives an idle fill. The line advances one bit per clock.

A set of static control inputs selects:
- the check-sequence width (16 or 32 bits);
- whether the check sequence is sent;
- the idle pattern (flags or all ones);
- whether scrambling is on;
- which end of each byte goes first.

A compatibility profile forces a 32-bit check sequence, always sends it, and forces flag fill, whatever the other inputs say. A single-cycle request input corrupts the check sequence of the next frame.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is low, `tx_bit` is 1 and `s_ready` is 0. After reset, one unscrambled 7Eh flag goes out, and the line then follows the live settings.
- R2: Each frame starts with one 7Eh flag and ends with one 7Eh flag. If the next packet is already valid when a closing flag ends, that flag also opens the next frame.
- R3: With `cfg_lsb_first`=0, bit 7 of each byte is sent first. With `cfg_lsb_first`=1, bit 0 is sent first.
- R4: After five consecutive ones in the payload or check sequence, the block sends a 0. This holds even when the next bit is the closing flag. Flags and fill are never stuffed.
- R5: The 32-bit check sequence is computed over the payload bits in the order they are sent. It uses the reflected polynomial EDB88320h, is preset to all ones, and is sent complemented with bit 0 first.
- R6: With `cfg_fcs16`=1, a 16-bit check sequence is used. It uses the reflected polynomial 8408h, with the same preset, complement and bit order as R5.
- R7: With `cfg_fcs_off`=1, the closing flag follows the last payload bit directly.
- R8: Idle fill is all ones when `cfg_fill_ones`=1. Otherwise it repeats 7Eh. When `cfg_byte_sync`=1, `cfg_fill_ones` is ignored and the fill is 7Eh.
- R9: With `cfg_scr_off`=0, each line bit is the stuffed bit XOR the line bit sent 43 clocks earlier. With `cfg_scr_off`=1, the stuffed bit is sent unchanged.
- R10: With `cfg_compat`=1, the block uses a 32-bit check sequence, always sends it, and fills idle time with 7Eh. `cfg_fcs16`, `cfg_fcs_off` and `cfg_fill_ones` then have no effect.
- R11: A pulse on `err_req` inverts the first check-sequence bit of the first frame that starts after the pulse. It affects that one frame only.
- R12: The settings are taken when a frame starts and at each fill-octet boundary. A change made while a frame is in flight takes effect only from the next boundary.
- R13: `s_ready` is high for at most one cycle per byte. A byte is taken when `s_valid` and `s_ready` are both high, and `s_last` on that byte ends the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fcs_off | input | 1 | 1: send no check sequence |
| cfg_fcs16 | input | 1 | 1: 16-bit check sequence; 0: 32-bit |
| cfg_fill_ones | input | 1 | 1: all-ones idle fill; 0: flag fill |
| cfg_scr_off | input | 1 | 1: scrambler bypassed |
| cfg_lsb_first | input | 1 | 1: bit 0 of each byte is sent first |
| cfg_compat | input | 1 | Compatibility profile (32-bit check sequence, always sent, flag fill) |
| cfg_byte_sync | input | 1 | Byte-synchronous line; forces flag fill |
| err_req | input | 1 | Single-cycle request to corrupt the next frame's check sequence |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | `s_data` and `s_last` are valid |
| s_last | input | 1 | Current byte is the last byte of the packet |
| s_ready | output | 1 | Byte accepted this cycle when `s_valid` is high |
| tx_bit | output | 1 | Serial line bit, registered |

## Verification
The assertions assume three things about the inputs:
- Once a packet's first byte has been offered, `s_valid` stays high until its last byte has been taken.
- The settings do not change while a corruption request is pending.
- `err_req` is a single-cycle pulse.

The bench presents bytes from a queue that is emptied only by handshakes, so valid never drops inside a packet. Settings are changed only at negative edges: mid-frame changes are made only in the phase that tests R12, and never while an error request is pending. Every request pulse lasts exactly one cycle.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   typedef enum logic [2:0] {
      U_FILL  = 3'd0,
      U_OPEN  = 3'd1,
      U_DATA  = 3'd2,
      U_FCS   = 3'd3,
      U_CLOSE = 3'd4
   } unit_e;

   typedef struct packed {
      logic short_fcs;
      logic add_fcs;
      logic scr_en;
      logic lsb_first;
   } cfg_t;

   localparam logic [7:0] FLAG_OCTET = 8'h7E;

   function automatic cfg_t derive_cfg(input logic fcs_off, input logic fcs16,
                                       input logic scr_off, input logic lsb,
                                       input logic compat);
      cfg_t c;
      c.short_fcs = fcs16 & ~compat;
      c.add_fcs   = ~fcs_off | compat;
      c.scr_en    = ~scr_off;
      c.lsb_first = lsb;
      return c;
   endfunction

endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
   parameter int          W    = 32,
   parameter logic [W-1:0] POLY = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] crc_nxt
);
   logic [W-1:0] crc_q;

   if (W < 8) begin : g_bad_w
      $error("hdlc_tx_fcs: W must be at least 8");
   end

   always_comb begin
      crc_nxt = crc_q;
      if (shift) begin
         crc_nxt = {1'b0, crc_q[W-1:1]} ^ ((crc_q[0] ^ din) ? POLY : '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= '1;
      else if (init) crc_q <= '1;
      else           crc_q <= crc_nxt;
   end
endmodule

// File: rtl/hdlc_tx_scrambler.sv
module hdlc_tx_scrambler #(
   parameter int LAG = 43
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic din,
   output logic dout
);
   logic [LAG-1:0] hist_q;

   if (LAG < 2) begin : g_bad_lag
      $error("hdlc_tx_scrambler: LAG must be at least 2");
   end

   assign dout = enable ? (din ^ hist_q[LAG-1]) : din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= {hist_q[LAG-2:0], dout};
   end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
   import hdlc_tx_pkg::*;
#(
   parameter int          BYTE_W      = 8,
   parameter int          SCR_LAG     = 43,
   parameter int          FCS_LONG_W  = 32,
   parameter int          FCS_SHORT_W = 16,
   parameter logic [31:0] POLY_LONG   = 32'hEDB88320,
   parameter logic [15:0] POLY_SHORT  = 16'h8408,
   parameter int          STUFF_RUN   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_fcs_off,
   input  logic              cfg_fcs16,
   input  logic              cfg_fill_ones,
   input  logic              cfg_scr_off,
   input  logic              cfg_lsb_first,
   input  logic              cfg_compat,
   input  logic              cfg_byte_sync,
   input  logic              err_req,
   input  logic [BYTE_W-1:0] s_data,
   input  logic              s_valid,
   input  logic              s_last,
   output logic              s_ready,
   output logic              tx_bit
);
   localparam int SH_W  = FCS_LONG_W;
   localparam int CNT_W = $clog2(SH_W + 1);
   localparam int RUN_W = $clog2(STUFF_RUN + 1);

   if (BYTE_W != 8) begin : g_bad_byte
      $error("hdlc_tx_framer: BYTE_W must be 8 to match the flag octet");
   end
   if (FCS_SHORT_W >= FCS_LONG_W || FCS_LONG_W != 32 || FCS_SHORT_W != 16) begin : g_bad_fcs
      $error("hdlc_tx_framer: check-sequence widths must be 16 and 32");
   end
   if (STUFF_RUN < 1) begin : g_bad_run
      $error("hdlc_tx_framer: STUFF_RUN must be positive");
   end

   unit_e            kind_q;
   logic [SH_W-1:0]  sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic [RUN_W-1:0] ones_q;
   cfg_t             cfg_q, cfg_live, cfg_use;
   logic             last_q, pend_q, armed_q, tx_q;

   logic stuff, raw_bit, adv, unit_end, fill_ones_live;
   logic frame_start, want_data, take, end_pl, go_fill, go_open, go_fcs, go_close;
   logic [BYTE_W-1:0] data_rev, byte_tx;
   logic [FCS_LONG_W-1:0]  crc_l_nxt;
   logic [FCS_SHORT_W-1:0] crc_s_nxt;
   logic [SH_W-1:0] fcs_word;
   logic tx_next;

   // Bit engine: a pending stuffed zero stalls the shifter for one cycle
   assign stuff    = (ones_q == RUN_W'(STUFF_RUN));
   assign raw_bit  = stuff ? 1'b0 : sh_q[0];
   assign adv      = ~stuff;
   assign unit_end = adv && (cnt_q == CNT_W'(1));

   assign cfg_live       = derive_cfg(cfg_fcs_off, cfg_fcs16, cfg_scr_off, cfg_lsb_first, cfg_compat);
   assign fill_ones_live = cfg_fill_ones & ~cfg_byte_sync & ~cfg_compat;

   always_comb begin
      frame_start = 1'b0;
      want_data   = 1'b0;
      end_pl      = 1'b0;
      go_fill     = 1'b0;
      go_open     = 1'b0;
      go_close    = 1'b0;
      if (unit_end) begin
         unique case (kind_q)
            U_FILL:  if (s_valid) begin frame_start = 1'b1; go_open = 1'b1; end
                     else go_fill = 1'b1;
            U_OPEN:  want_data = 1'b1;
            U_DATA:  if (last_q) end_pl = 1'b1; else want_data = 1'b1;
            U_FCS:   go_close = 1'b1;
            U_CLOSE: if (s_valid) begin frame_start = 1'b1; want_data = 1'b1; end
                     else go_fill = 1'b1;
            default: go_fill = 1'b1;
         endcase
      end
      take = want_data & s_valid;
      if (want_data && !s_valid) end_pl = 1'b1;
      go_fcs = end_pl & cfg_q.add_fcs;
      if (end_pl && !cfg_q.add_fcs) go_close = 1'b1;
   end

   assign s_ready = want_data;
   assign cfg_use = frame_start ? cfg_live : cfg_q;

   for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_rev
      assign data_rev[gi] = s_data[BYTE_W-1-gi];
   end
   assign byte_tx = cfg_use.lsb_first ? s_data : data_rev;

   // Both check-sequence widths run side by side; the snapshot picks one
   hdlc_tx_fcs #(.W(FCS_LONG_W), .POLY(POLY_LONG)) u_fcs_long (
      .clk(clk), .rst_n(rst_n), .init(frame_start),
      .shift(adv && kind_q == U_DATA), .din(raw_bit), .crc_nxt(crc_l_nxt));

   hdlc_tx_fcs #(.W(FCS_SHORT_W), .POLY(POLY_SHORT)) u_fcs_short (
      .clk(clk), .rst_n(rst_n), .init(frame_start),
      .shift(adv && kind_q == U_DATA), .din(raw_bit), .crc_nxt(crc_s_nxt));

   always_comb begin
      if (cfg_q.short_fcs) fcs_word = {{(SH_W-FCS_SHORT_W){1'b0}}, ~crc_s_nxt};
      else                 fcs_word = ~crc_l_nxt;
      fcs_word[0] = fcs_word[0] ^ armed_q;
   end

   hdlc_tx_scrambler #(.LAG(SCR_LAG)) u_scr (
      .clk(clk), .rst_n(rst_n), .enable(cfg_q.scr_en), .din(raw_bit), .dout(tx_next));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= U_FILL;
         sh_q    <= {{(SH_W-BYTE_W){1'b0}}, FLAG_OCTET};
         cnt_q   <= CNT_W'(BYTE_W);
         ones_q  <= '0;
         cfg_q   <= '0;
         last_q  <= 1'b0;
         pend_q  <= 1'b0;
         armed_q <= 1'b0;
         tx_q    <= 1'b1;
      end else begin
         tx_q <= tx_next;
         if (stuff)                                   ones_q <= '0;
         else if (kind_q == U_DATA || kind_q == U_FCS) ones_q <= raw_bit ? ones_q + RUN_W'(1) : '0;
         else                                         ones_q <= '0;

         if (err_req)          pend_q <= 1'b1;
         else if (frame_start) pend_q <= 1'b0;
         if (frame_start) begin
            armed_q <= pend_q;
            cfg_q   <= cfg_live;
         end

         if (adv) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - CNT_W'(1);
         end
         if (go_fill) begin
            kind_q <= U_FILL;
            cfg_q  <= cfg_live;
            sh_q   <= fill_ones_live ? {{(SH_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}}
                                     : {{(SH_W-BYTE_W){1'b0}}, FLAG_OCTET};
            cnt_q  <= CNT_W'(BYTE_W);
         end else if (go_open || go_close) begin
            kind_q <= go_open ? U_OPEN : U_CLOSE;
            sh_q   <= {{(SH_W-BYTE_W){1'b0}}, FLAG_OCTET};
            cnt_q  <= CNT_W'(BYTE_W);
         end else if (take) begin
            kind_q <= U_DATA;
            sh_q   <= {{(SH_W-BYTE_W){1'b0}}, byte_tx};
            cnt_q  <= CNT_W'(BYTE_W);
            last_q <= s_last;
         end else if (go_fcs) begin
            kind_q <= U_FCS;
            sh_q   <= fcs_word;
            cnt_q  <= cfg_q.short_fcs ? CNT_W'(FCS_SHORT_W) : CNT_W'(FCS_LONG_W);
         end
      end
   end

   assign tx_bit = tx_q;
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
   import hdlc_tx_pkg::*;
#(
   parameter int STUFF_RUN = 5
) (
   input logic  clk,
   input logic  rst_n,
   input logic  s_ready,
   input unit_e kind_q,
   input logic  raw_bit,
   input logic  stuff,
   input logic  tx_next,
   input cfg_t  cfg_q
);
   int run_c;
   logic stuffable;
   assign stuffable = (kind_q == U_DATA) || (kind_q == U_FCS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    run_c <= 0;
      else if (stuffable && raw_bit) run_c <= run_c + 1;
      else                           run_c <= 0;
   end

   // R4: never more than five ones in a row inside the stuffed field
   p_stuff_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stuffable && raw_bit) |-> (run_c < STUFF_RUN));

   // R4: an opening flag is never broken by a stuffed zero
   p_flag_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == U_OPEN) |-> !stuff);

   // R13: at most one byte accepted per cycle pair
   p_ready_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |=> !s_ready);

   // R12: the settings snapshot holds while the frame body is in flight
   p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == U_OPEN || kind_q == U_DATA || kind_q == U_FCS) |=> $stable(cfg_q));

   // R9: with the scrambler bypassed, the line takes the stuffed bit unchanged
   p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q.scr_en |-> (tx_next == raw_bit));
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.STUFF_RUN(STUFF_RUN)) chk_i (
   .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .kind_q(kind_q),
   .raw_bit(raw_bit), .stuff(stuff), .tx_next(tx_next), .cfg_q(cfg_q));

// File: tb/hdlc_tx_framer_tb_top.sv
`timescale 1ns/1ps
module hdlc_tx_framer_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_fcs_off = 0, cfg_fcs16 = 0, cfg_fill_ones = 0, cfg_scr_off = 0;
   logic cfg_lsb_first = 0, cfg_compat = 0, cfg_byte_sync = 0, err_req = 0;
   logic [7:0] s_data = '0;
   logic s_valid = 0, s_last = 0;
   logic s_ready, tx_bit;

   always #2.5 clk = ~clk;

   hdlc_tx_framer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_fcs_off(cfg_fcs_off), .cfg_fcs16(cfg_fcs16),
      .cfg_fill_ones(cfg_fill_ones), .cfg_scr_off(cfg_scr_off), .cfg_lsb_first(cfg_lsb_first),
      .cfg_compat(cfg_compat), .cfg_byte_sync(cfg_byte_sync), .err_req(err_req),
      .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready), .tx_bit(tx_bit));

   int tests = 0, fails = 0, offered = 0, consumed = 0;
   logic [8:0] dq[$];
   logic [8:0] mq[$];
   bit         eq[$];
   string      tq[$];
   bit         hq[$];
   bit    m_scr, m_close, m_pend, exp_bit, cmp_on, done;
   int    m_run;
   string exp_tag, ph;

   task automatic push_bit(input bit b, input string t);
      eq.push_back(b);
      tq.push_back(t);
   endtask

   task automatic push_flag(input string t);
      for (int i = 0; i < 8; i++) push_bit((8'h7E >> i) & 1, t);
      m_run = 0;
   endtask

   task automatic push_stuffed(input bit b, input string t);
      push_bit(b, t);
      m_run = b ? m_run + 1 : 0;
      if (m_run == 5) begin
         push_bit(1'b0, "R4");
         m_run = 0;
      end
   endtask

   function automatic int unsigned crc_step(input int unsigned c, input bit b, input bit short16);
      bit fb = c[0] ^ b;
      c = c >> 1;
      if (fb) c = c ^ (short16 ? 32'h8408 : 32'hEDB88320);
      return c;
   endfunction

   task automatic refill();
      if (s_valid) begin
         bit c_add = cfg_compat || !cfg_fcs_off;
         bit c16   = !cfg_compat && cfg_fcs16;
         bit lsb   = cfg_lsb_first;
         bit err   = m_pend;
         int unsigned crc = c16 ? 32'h0000FFFF : 32'hFFFFFFFF;
         logic [8:0] e;
         m_scr  = !cfg_scr_off;
         m_pend = 0;
         if (!m_close) push_flag("R2");
         m_run = 0;
         do begin
            e = mq.pop_front();
            for (int i = 0; i < 8; i++) begin
               bit b = lsb ? e[i] : e[7-i];
               crc = crc_step(crc, b, c16);
               push_stuffed(b, "R3");
            end
         end while (!e[8] && mq.size() > 0);
         if (c_add) begin
            int unsigned f = ~crc;
            int w = c16 ? 16 : 32;
            if (err) f[0] = ~f[0];
            for (int i = 0; i < w; i++)
               push_stuffed(f[i], (err && i == 0) ? "R11" : (c16 ? "R6" : "R5"));
         end
         push_flag("R2");
         m_close = 1;
      end else begin
         bit ones = cfg_fill_ones && !cfg_byte_sync && !cfg_compat;
         m_scr = !cfg_scr_off;
         if (ones) for (int i = 0; i < 8; i++) push_bit(1'b1, "R8");
         else push_flag("R8");
         m_close = 0;
      end
   endtask

   // Reference model: one line bit per clock
   always @(posedge clk) begin
      if (!rst_n) begin
         eq.delete(); tq.delete(); hq.delete();
         for (int i = 0; i < 43; i++) hq.push_back(1'b0);
         push_flag("R1");
         m_scr = 0; m_close = 0; m_pend = 0; exp_bit = 1; exp_tag = "R1"; cmp_on = 1;
      end else begin
         bit b, o;
         if (s_valid && s_ready && dq.size() > 0) begin
            consumed++;
            void'(dq.pop_front());
         end
         b = eq.pop_front();
         exp_tag = tq.pop_front();
         o = m_scr ? (b ^ hq[0]) : b;
         void'(hq.pop_front());
         hq.push_back(o);
         exp_bit = o;
         if (eq.size() == 0) refill();
         if (err_req) m_pend = 1;
      end
   end

   // Compare and drive away from the active edge
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         tests++;
         if (tx_bit !== exp_bit) begin
            fails++;
            $display("FAIL %s line bit (phase %s) actual=%0b expected=%0b t=%0t",
                     exp_tag, ph, tx_bit, exp_bit, $time);
         end
      end
      s_valid = dq.size() > 0;
      if (dq.size() > 0) begin
         s_data = dq[0][7:0];
         s_last = dq[0][8];
      end
   end

   task automatic add_pkt(input int n, input int seed, input bit allff);
      for (int i = 0; i < n; i++) begin
         logic [8:0] e;
         e[7:0] = allff ? 8'hFF : 8'((seed * 37 + i * 11 + 5) & 8'hFF);
         e[8]   = (i == n - 1);
         dq.push_back(e);
         mq.push_back(e);
         offered++;
      end
   endtask

   task automatic drain();
      while (dq.size() > 0) @(negedge clk);
      repeat (150) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      done = 0; cmp_on = 0; ph = "R1 reset";
      repeat (3) @(negedge clk);
      tests++;
      if (tx_bit !== 1'b1 || s_ready !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset outputs actual=%0b%0b expected=10", tx_bit, s_ready);
      end
      rst_n = 1;
      repeat (60) @(negedge clk);

      ph = "R2 back-to-back default";
      add_pkt(3, 1, 0); add_pkt(4, 2, 0);
      drain();

      ph = "R3 R6 R4 lsb fcs16 bypass";
      cfg_lsb_first = 1; cfg_fcs16 = 1; cfg_scr_off = 1;
      add_pkt(3, 0, 1);
      drain();

      ph = "R7 no fcs";
      cfg_lsb_first = 0; cfg_fcs16 = 0; cfg_scr_off = 0; cfg_fcs_off = 1;
      add_pkt(5, 3, 0);
      drain();

      ph = "R8 ones fill";
      cfg_fcs_off = 0; cfg_fill_ones = 1;
      repeat (60) @(negedge clk);
      add_pkt(2, 4, 0);
      drain();
      ph = "R8 byte sync ignores fill select";
      cfg_byte_sync = 1;
      repeat (60) @(negedge clk);
      cfg_byte_sync = 0;

      ph = "R10 compat overrides";
      cfg_compat = 1; cfg_fcs16 = 1; cfg_fcs_off = 1;
      repeat (40) @(negedge clk);
      add_pkt(3, 5, 0);
      drain();
      cfg_compat = 0; cfg_fcs16 = 0; cfg_fcs_off = 0; cfg_fill_ones = 0;

      ph = "R11 error insertion";
      err_req = 1; @(negedge clk); err_req = 0;
      add_pkt(3, 6, 0);
      drain();
      add_pkt(3, 6, 0);
      drain();

      ph = "R12 mid-frame change";
      add_pkt(6, 7, 0);
      repeat (30) @(negedge clk);
      cfg_lsb_first = 1; cfg_fcs16 = 1; cfg_scr_off = 1;
      drain();
      add_pkt(2, 8, 0);
      drain();

      ph = "R9 R4 scrambled stuffing";
      cfg_lsb_first = 0; cfg_fcs16 = 0; cfg_scr_off = 0;
      add_pkt(4, 0, 1);
      drain();

      tests++;
      if (consumed != offered) begin
         fails++;
         $display("FAIL R13 bytes consumed actual=%0d expected=%0d", consumed, offered);
      end
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      finish_run();
   end
endmodule